// File: doc/BRIEF.md
# Half-Bridge Fault Supervisor

This block supervises the protection of one half-bridge gate driver. It takes four inputs: a digital over-current comparator flag, a supply under-voltage flag, an active-low shutdown request, and the sensed level of a shared open-drain fault line. It produces three kinds of output. The first is the pull-down enable for that fault line. The second is a soft turn-off request for the low-side gate. The third is a pair of disable signals for the downstream interlock stage. All filter and pulse durations are parameters counted in clock cycles.

Over-current and under-voltage each pass through their own qualification filter. The filter counter restarts whenever the flag drops before the limit is reached. Three conditions count as a local fault: a qualified over-current, a qualified under-voltage, or an asserted shutdown. A local fault disables both gates and pulls the fault line low for a fixed pulse. If the cause was over-current or under-voltage, the block also requests soft-off for the duration of that pulse. When another device pulls the line low while the bridge is running, the block disables its gates in the same way, but it does not pull the line itself. Each fault episode produces at most one pulse. The gates are enabled again only when three things are true: the pulse has ended, every local source is gone, and the sensed line is high.

Top module: `gd_fault_ctrl`

## Requirements
- R1: While reset is asserted and on the cycle after it is released, `flt_pull` and `soft_off` are 0 and `lo_dis` and `hi_dis` are 1. If all inputs are clear, both disables fall one cycle after reset is released.
- R2: `oc_flag` only counts as a fault after it has been high on OC_FILT consecutive clock edges. A shorter run, or two short runs separated by a single low cycle, has no visible effect on any output.
- R3: Suppose `oc_flag` first rises so that it is sampled high at edge 1 while the bridge is running. Then `flt_pull` and both disables become 1 after edge OC_FILT+1, and `flt_pull` stays 1 for exactly PULSE_LEN cycles.
- R4: `uv_flag` is qualified the same way with its own UV_FILT length. A qualified under-voltage produces the same pulse as in R3, starting after edge UV_FILT+1.
- R5: `soft_off` is 1 on exactly the cycles of a pulse caused by over-current or under-voltage. It is never 1 for a pulse caused by shutdown, and never 1 for an external fault.
- R6: If `shdn_n` is sampled at 0 while the bridge is running, `flt_pull` and both disables become 1 after that same edge. The pulse lasts PULSE_LEN cycles even if `shdn_n` returns high at once.
- R7: If `flt_sense` is sampled at 0 while the bridge is running and no local fault is present, both disables become 1 after that edge and `flt_pull` stays 0.
- R8: While its own pulse is active, the block ignores `flt_sense` as an input. If nothing external holds the line, the gates come back one cycle after the pulse ends. If an external device still holds the line low, the gates stay off until it releases.
- R9: Re-enable happens on the first edge after the pulse at which the following hold together: the over-current and under-voltage filters are unqualified, `shdn_n` is 1, and `flt_sense` is 1. A source that persists past the pulse does not start a second pulse.
- R10: `hi_dis` and `lo_dis` are equal on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| oc_flag | input | 1 | Over-current comparator output, 1 = over threshold |
| uv_flag | input | 1 | Supply under-voltage flag, 1 = supply low |
| shdn_n | input | 1 | Shutdown request, active low |
| flt_sense | input | 1 | Sensed fault line level, 0 = line pulled low |
| flt_pull | output | 1 | Enable for the fault line pull-down, 1 = pull low |
| soft_off | output | 1 | Soft turn-off request for the low-side gate |
| lo_dis | output | 1 | Low-side disable to the interlock stage |
| hi_dis | output | 1 | High-side disable to the interlock stage |

## Verification
All outputs decode from a single state register, so every response has a fixed cycle position:
- A shutdown or an external pull-down shows after the edge that samples it.
- A qualified over-current shows after edge OC_FILT+1, and an under-voltage after edge UV_FILT+1.
- The pulse lasts PULSE_LEN cycles.
- Re-enable comes on the edge after the last of the conditions in R9 clears.

The bench drives inputs and samples outputs on the falling edge, indexing each sample by the number of rising edges since stimulus began. For each scenario it records where the pulse and the disable window start and end, and how long they last. It then compares these against closed-form expressions in the filter lengths, the pulse length and the stimulus widths, including maxima where several release conditions overlap.

// File: rtl/gd_fault_pkg.sv
package gd_fault_pkg;

  typedef enum logic [1:0] {
    GD_HOLD  = 2'd0,
    GD_RUN   = 2'd1,
    GD_PULSE = 2'd2
  } gd_state_e;

  // bits needed to hold the values 0..n
  function automatic int cnt_bits(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/gd_qual_filter.sv
module gd_qual_filter #(
  parameter int LIMIT = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_flag,
  output logic qual
);
  import gd_fault_pkg::*;

  localparam int CW = cnt_bits(LIMIT);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!in_flag)   cnt_q <= '0;
    else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign qual = (cnt_q == LIM);

  // R2
  qual_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qual) |-> $past(in_flag));

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM);

endmodule

// File: rtl/gd_pulse_timer.sv
module gd_pulse_timer #(
  parameter int LEN = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  import gd_fault_pkg::*;

  localparam int CW = cnt_bits(LEN);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (run) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    else          cnt_q <= '0;
  end

  assign done = run && (cnt_q == LAST);

  // R3
  timer_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> $past(run));

  // R3
  timer_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/gd_fault_ctrl.sv
module gd_fault_ctrl #(
  parameter int OC_FILT   = 15,
  parameter int UV_FILT   = 800,
  parameter int PULSE_LEN = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oc_flag,
  input  logic uv_flag,
  input  logic shdn_n,
  input  logic flt_sense,
  output logic flt_pull,
  output logic soft_off,
  output logic lo_dis,
  output logic hi_dis
);
  import gd_fault_pkg::*;

  gd_state_e state_q, state_d;
  logic      soft_cause_q, soft_cause_d;

  // named internal events
  logic oc_q, uv_q, local_trig, pulse_done, in_run, in_pulse;

  gd_qual_filter #(.LIMIT(OC_FILT)) u_oc_filt (
    .clk(clk), .rst_n(rst_n), .in_flag(oc_flag), .qual(oc_q));

  gd_qual_filter #(.LIMIT(UV_FILT)) u_uv_filt (
    .clk(clk), .rst_n(rst_n), .in_flag(uv_flag), .qual(uv_q));

  gd_pulse_timer #(.LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .run(in_pulse), .done(pulse_done));

  assign local_trig = oc_q | uv_q | ~shdn_n;
  assign in_run     = (state_q == GD_RUN);
  assign in_pulse   = (state_q == GD_PULSE);

  always_comb begin
    state_d      = state_q;
    soft_cause_d = soft_cause_q;
    unique case (state_q)
      GD_HOLD: begin
        if (!local_trig && flt_sense) state_d = GD_RUN;
      end
      GD_RUN: begin
        if (local_trig) begin
          state_d      = GD_PULSE;
          soft_cause_d = oc_q | uv_q;
        end else if (!flt_sense) begin
          state_d = GD_HOLD;
        end
      end
      GD_PULSE: begin
        if (pulse_done) begin
          state_d      = GD_HOLD;
          soft_cause_d = 1'b0;
        end
      end
      default: state_d = GD_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= GD_HOLD;
      soft_cause_q <= 1'b0;
    end else begin
      state_q      <= state_d;
      soft_cause_q <= soft_cause_d;
    end
  end

  assign flt_pull = in_pulse;
  assign soft_off = in_pulse & soft_cause_q;
  assign lo_dis   = ~in_run;
  assign hi_dis   = ~in_run;

  // R3
  oc_pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && oc_q) |=> (flt_pull && soft_off && lo_dis));

  // R6
  sd_pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && !shdn_n) |=> (flt_pull && lo_dis && hi_dis));

  // R7
  ext_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && !flt_sense && !local_trig) |=> (lo_dis && !flt_pull));

  // R9
  reenable_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lo_dis) |-> ($past(flt_sense) && !$past(local_trig) && !$past(flt_pull)));

  // R5
  soft_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(soft_off) |-> $past(oc_q || uv_q));

  // R8
  pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pulse && !pulse_done) |=> flt_pull);

endmodule

// File: tb/gd_fault_ctrl_bench.sv
module gd_fault_ctrl_bench;

  localparam int OCF = 3;
  localparam int UVF = 6;
  localparam int PL  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic oc_flag = 1'b0, uv_flag = 1'b0, shdn_n = 1'b1, ext_pull = 1'b0;
  logic flt_sense, flt_pull, soft_off, lo_dis, hi_dis;

  assign flt_sense = ~(flt_pull | ext_pull);

  always #10 clk = ~clk;

  gd_fault_ctrl #(.OC_FILT(OCF), .UV_FILT(UVF), .PULSE_LEN(PL)) u_gd_fault_ctrl (
    .clk(clk), .rst_n(rst_n), .oc_flag(oc_flag), .uv_flag(uv_flag),
    .shdn_n(shdn_n), .flt_sense(flt_sense), .flt_pull(flt_pull),
    .soft_off(soft_off), .lo_dis(lo_dis), .hi_dis(hi_dis));

  int n_chk = 0, n_fail = 0;
  int first_pull, pull_cnt, soft_cnt, soft_out, first_dis, last_dis, dis_cnt, mism;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic settle();
    oc_flag = 0; uv_flag = 0; shdn_n = 1; ext_pull = 0;
    repeat (4) @(negedge clk);
  endtask

  // stimulus for cycle c is sampled at edge c+1; observation k follows edge k
  task automatic run_case(input int oc_w, input int oc_gap, input int uv_w,
                          input int sd_w, input int ext_s, input int ext_e,
                          input int ncyc);
    first_pull = 0; pull_cnt = 0; soft_cnt = 0; soft_out = 0;
    first_dis = 0; last_dis = 0; dis_cnt = 0; mism = 0;
    for (int c = 0; c <= ncyc; c++) begin
      if (c > 0) begin
        if (flt_pull) begin
          pull_cnt++;
          if (first_pull == 0) first_pull = c;
        end
        if (soft_off) soft_cnt++;
        if (soft_off && !flt_pull) soft_out++;
        if (lo_dis) begin
          dis_cnt++;
          if (first_dis == 0) first_dis = c;
          last_dis = c;
        end
        if (lo_dis != hi_dis) mism++;
      end
      oc_flag  = (c < oc_w) && (c != oc_gap);
      uv_flag  = (c < uv_w);
      shdn_n   = !(c < sd_w);
      ext_pull = (c >= ext_s) && (c < ext_e);
      @(negedge clk);
    end
    settle();
  endtask

  task automatic expect_pulse(input string req, input int start, input int lastd,
                              input int soft_exp);
    chk({req, " pulse start"}, first_pull, start);
    chk({req, " pulse length"}, pull_cnt, PL);
    chk({req, " soft-off count"}, soft_cnt, soft_exp);
    chk({req, " soft-off outside pulse"}, soft_out, 0);
    chk({req, " disable start"}, first_dis, start);
    chk({req, " disable end"}, last_dis, lastd);
    chk({req, " disable contiguous"}, dis_cnt, lastd - start + 1);
    chk("R10 hi/lo disable equal", mism, 0);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1 reset state
    chk("R1 reset flt_pull", int'(flt_pull), 0);
    chk("R1 reset soft_off", int'(soft_off), 0);
    chk("R1 reset lo_dis", int'(lo_dis), 1);
    chk("R1 reset hi_dis", int'(hi_dis), 1);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 enable after one edge", int'(lo_dis), 0);
    chk("R1 hi enable after one edge", int'(hi_dis), 0);
    settle();

    // R2 R3 over-current width sweep
    for (int w = 1; w <= OCF + 3; w++) begin
      run_case(w, -1, 0, 0, 0, 0, PL + w + 10);
      if (w < OCF) begin
        chk("R2 short oc no pull", pull_cnt, 0);
        chk("R2 short oc no disable", dis_cnt, 0);
      end else begin
        expect_pulse("R3 oc", OCF + 1, imax(OCF + PL + 1, w + 1), PL);
      end
    end
    // R2 restart: two runs of OCF-1 split by one low cycle
    run_case(2 * OCF - 1, OCF - 1, 0, 0, 0, 0, PL + 10);
    chk("R2 restarted filter no pull", pull_cnt, 0);
    chk("R2 restarted filter no disable", dis_cnt, 0);

    // R4 under-voltage sweep
    for (int w = UVF - 2; w <= UVF + 2; w++) begin
      run_case(0, -1, w, 0, 0, 0, PL + w + 10);
      if (w < UVF) chk("R4 short uv no pull", pull_cnt + dis_cnt, 0);
      else expect_pulse("R4 uv", UVF + 1, imax(UVF + PL + 1, w + 1), PL);
    end

    // R9 persistent over-current: one pulse only
    run_case(PL + 20, -1, 0, 0, 0, 0, PL + 30);
    expect_pulse("R9 persistent oc", OCF + 1, PL + 21, PL);

    // R5 R6 shutdown sweep, no soft-off
    for (int w = 1; w <= PL + 4; w += 3) begin
      run_case(0, -1, 0, w, 0, 0, PL + w + 8);
      expect_pulse("R6 shutdown", 1, imax(PL + 1, w), 0);
      chk("R5 no soft-off on shutdown", soft_cnt, 0);
    end

    // R7 external pull while running
    for (int len = 1; len <= 4; len++) begin
      run_case(0, -1, 0, 0, 2, 2 + len, 12);
      chk("R7 ext no pull", pull_cnt, 0);
      chk("R7 ext disable start", first_dis, 3);
      chk("R7 ext disable end", last_dis, 2 + len);
      chk("R5 ext no soft-off", soft_cnt, 0);
    end

    // R8 external inside own pulse, and extending beyond it
    run_case(OCF, -1, 0, 0, 5, 9, PL + 12);
    expect_pulse("R8 ext inside pulse", OCF + 1, OCF + PL + 1, PL);
    run_case(OCF, -1, 0, 0, 5, OCF + PL + 6, PL + 20);
    expect_pulse("R8 ext past pulse", OCF + 1, OCF + PL + 6, PL);

    // R1 reset during a pulse releases line
    shdn_n = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R6 pulse active before reset", int'(flt_pull), 1);
    rst_n = 0;
    shdn_n = 1;
    @(negedge clk);
    chk("R1 reset mid-pulse flt_pull", int'(flt_pull), 0);
    chk("R1 reset mid-pulse lo_dis", int'(lo_dis), 1);
    chk("R1 reset mid-pulse soft_off", int'(soft_off), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 re-enable after reset", int'(lo_dis), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule